// File: doc/BRIEF.md
# Routed-interrupt GPIO port

A memory-mapped general purpose I/O port with up to 32 lines. It sits behind a simple 32-bit register bus with separate write and read strobes. Each line can be driven from an output register when its direction bit is set. The level on every pin can be read back after a two-flop synchroniser.

Every line can raise an interrupt. Each line has its own mask bit. A polarity bit and an edge bit together pick one of four trigger modes. A routing register per line sends the line to one of several shared interrupt outputs, or to none. An output is the OR of all unmasked, active lines that are routed to it. In edge mode a line gives a single-cycle pulse. In level mode it holds its output high while the pin stays at the active level.

Top module: `gpio_irq_port`

## Requirements
- R1: The line count parameter takes values 1 to 32. Any other value gives 32 lines. Register bits at and above the line count read as 0, and writes to them have no effect.
- R2: The registers sit at these word offsets: pin levels 0x00 (read only), output value 0x04, direction 0x08, interrupt mask 0x0C, polarity 0x10, edge select 0x14. Offset 0x18 always reads 0 and ignores writes. The routing register of line n sits at 0x20+4n. Read data appears on `bus_rdata` one cycle after `bus_re` and holds until the next read. Bit n of each register belongs to line n, so one bit can be changed by read-modify-write.
- R3: `pin_oe[n]` equals direction bit n, and `pin_out[n]` equals output bit n. Both change on the clock edge that takes the write.
- R4: A read of offset 0x00 returns the pin levels through a two-flop synchroniser. A pin change made before clock edge k is seen by a read whose strobe is sampled at edge k+2 or later. Reads sampled at edges k and k+1 return the old value.
- R5: The trigger mode of a line is set by its {polarity, edge} bits: 00 is level-low, 10 is level-high, 01 is falling edge, and 11 is rising edge.
- R6: In edge mode, a qualifying pin change made before edge k drives the routed output high for exactly one cycle, starting at edge k+2.
- R7: In level mode, the routed output stays high for as long as the pin stays at the active level. It goes high at edge k+2 after a change made before edge k.
- R8: A line with mask bit 0 has no effect on any interrupt output.
- R9: Bits [IW-1:0] of a routing register hold the target output index, and bit 8 holds the enable bit. A line reaches an output only when it is enabled and its index is less than the number of outputs. Several lines may share one output, which then carries their OR.
- R10: Reset clears direction, output, mask, polarity, edge and routing. After reset all lines are inputs, `pin_out` is 0, and every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NL | Pin levels from the pads |
| pin_out | output | NL | Output value toward the pads |
| pin_oe | output | NL | Output enable per line |
| irq_out | output | NOUT | Shared interrupt outputs |

## Verification
The hardest behaviour to reach is the exact single-cycle edge pulse on a shared output. It only shows when the pin history, the mode bits and the routing of several lines line up, and it comes two registers and a synchroniser away from the pin. The bench drives pins only on falling clock edges and keeps its own record of every value it applied. It predicts each output from the values applied two and three edges earlier. Random configurations, including unrouted and out-of-range indexes, are mixed with directed edge, level and sharing cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DIN   = 8'h00;
  localparam logic [7:0] OFS_DOUT  = 8'h04;
  localparam logic [7:0] OFS_DIR   = 8'h08;
  localparam logic [7:0] OFS_MASK  = 8'h0C;
  localparam logic [7:0] OFS_POL   = 8'h10;
  localparam logic [7:0] OFS_EDGE  = 8'h14;
  localparam logic [7:0] OFS_BYP   = 8'h18;
  localparam logic [7:0] OFS_ROUTE = 8'h20;
  localparam int ROUTE_EN_BIT = 8;
  localparam int MAX_LINES = 32;

  function automatic int clamp_lines(input int n);
    return (n < 1 || n > MAX_LINES) ? MAX_LINES : n;
  endfunction

  function automatic logic [7:0] route_addr(input int line);
    return OFS_ROUTE + 8'(4 * line);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NL = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] pin_in,
  output logic [NL-1:0] sync_o,
  output logic [NL-1:0] prev_o
);
  logic [NL-1:0] s1_q, s2_q, prev_q;
  logic [NL-1:0] s1_n, s2_n, prev_n;

  always_comb begin
    s1_n   = pin_in;
    s2_n   = s1_q;
    prev_n = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_n;
      s2_q   <= s2_n;
      prev_q <= prev_n;
    end
  end

  assign sync_o = s2_q;
  assign prev_o = prev_q;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (sync_o == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int NL = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] cur,
  input  logic [NL-1:0] prev,
  input  logic [NL-1:0] mask,
  input  logic [NL-1:0] pol,
  input  logic [NL-1:0] edg,
  output logic [NL-1:0] req
);
  logic [NL-1:0] edge_hit, lvl_hit, act;

  always_comb begin
    edge_hit = (pol & cur & ~prev) | (~pol & ~cur & prev);
    lvl_hit  = ~(cur ^ pol);
    act      = (edg & edge_hit) | (~edg & lvl_hit);
    req      = act & mask;
  end

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act & $past(act) & edg & $past(edg) & ~(pol ^ $past(pol))) == '0));
endmodule

// File: rtl/gpio_route.sv
module gpio_route #(
  parameter int NL   = 32,
  parameter int NOUT = 4,
  parameter int IW   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NL-1:0]          req,
  input  logic [NL-1:0][IW-1:0]  ridx,
  input  logic [NL-1:0]          ren,
  output logic [NOUT-1:0]        irq_o
);
  logic [NOUT-1:0] hit_n, irq_q;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [NL-1:0] sel;
    always_comb begin
      for (int i = 0; i < NL; i++) begin
        sel[i] = ren[i] && (ridx[i] == IW'(o));
      end
    end
    assign hit_n[o] = |(req & sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= hit_n;
  end

  assign irq_o = irq_q;

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NL = 32,
  parameter int IW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  re,
  input  logic [7:0]            addr,
  input  logic [31:0]           wdata,
  input  logic [NL-1:0]         din,
  output logic [31:0]           rdata,
  output logic [NL-1:0]         dir_o,
  output logic [NL-1:0]         dout_o,
  output logic [NL-1:0]         mask_o,
  output logic [NL-1:0]         pol_o,
  output logic [NL-1:0]         edg_o,
  output logic [NL-1:0][IW-1:0] ridx_o,
  output logic [NL-1:0]         ren_o
);
  logic [NL-1:0]         dir_q, dout_q, mask_q, pol_q, edg_q, ren_q;
  logic [NL-1:0]         dir_n, dout_n, mask_n, pol_n, edg_n, ren_n;
  logic [NL-1:0][IW-1:0] ridx_q, ridx_n;
  logic [31:0]           rd_q, rd_n;

  always_comb begin
    dir_n  = dir_q;
    dout_n = dout_q;
    mask_n = mask_q;
    pol_n  = pol_q;
    edg_n  = edg_q;
    ren_n  = ren_q;
    ridx_n = ridx_q;
    if (we) begin
      case (addr)
        OFS_DOUT: dout_n = wdata[NL-1:0];
        OFS_DIR:  dir_n  = wdata[NL-1:0];
        OFS_MASK: mask_n = wdata[NL-1:0];
        OFS_POL:  pol_n  = wdata[NL-1:0];
        OFS_EDGE: edg_n  = wdata[NL-1:0];
        default: ;
      endcase
      for (int i = 0; i < NL; i++) begin
        if (addr == route_addr(i)) begin
          ridx_n[i] = wdata[IW-1:0];
          ren_n[i]  = wdata[ROUTE_EN_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      OFS_DIN:  rd_n[NL-1:0] = din;
      OFS_DOUT: rd_n[NL-1:0] = dout_q;
      OFS_DIR:  rd_n[NL-1:0] = dir_q;
      OFS_MASK: rd_n[NL-1:0] = mask_q;
      OFS_POL:  rd_n[NL-1:0] = pol_q;
      OFS_EDGE: rd_n[NL-1:0] = edg_q;
      default: ;
    endcase
    for (int i = 0; i < NL; i++) begin
      if (addr == route_addr(i)) begin
        rd_n[IW-1:0]       = ridx_q[i];
        rd_n[ROUTE_EN_BIT] = ren_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edg_q  <= '0;
      ren_q  <= '0;
      ridx_q <= '0;
      rd_q   <= '0;
    end else begin
      dir_q  <= dir_n;
      dout_q <= dout_n;
      mask_q <= mask_n;
      pol_q  <= pol_n;
      edg_q  <= edg_n;
      ren_q  <= ren_n;
      ridx_q <= ridx_n;
      if (re) rd_q <= rd_n;
    end
  end

  assign rdata  = rd_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edg_o  = edg_q;
  assign ridx_o = ridx_q;
  assign ren_o  = ren_q;

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_DIR) |=> (dir_o == $past(wdata[NL-1:0])));

  // R2
  spare_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == OFS_BYP) |=> (rdata == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NLINES = 32,
  parameter int NOUT   = 4,
  localparam int NL    = gpio_pkg::clamp_lines(NLINES),
  localparam int IW    = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NL-1:0]   pin_in,
  output logic [NL-1:0]   pin_out,
  output logic [NL-1:0]   pin_oe,
  output logic [NOUT-1:0] irq_out
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NL-1:0]         cur, prev, dir, dout, mask, pol, edg, ren, req;
  logic [NL-1:0][IW-1:0] ridx;

  gpio_sync #(.NL(NL)) u_sync (
    .clk(clk), .rst_n(rst_sync_q), .pin_in(pin_in),
    .sync_o(cur), .prev_o(prev)
  );

  gpio_regs #(.NL(NL), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .we(bus_we), .re(bus_re),
    .addr(bus_addr), .wdata(bus_wdata), .din(cur), .rdata(bus_rdata),
    .dir_o(dir), .dout_o(dout), .mask_o(mask), .pol_o(pol), .edg_o(edg),
    .ridx_o(ridx), .ren_o(ren)
  );

  gpio_detect #(.NL(NL)) u_detect (
    .clk(clk), .rst_n(rst_sync_q), .cur(cur), .prev(prev),
    .mask(mask), .pol(pol), .edg(edg), .req(req)
  );

  gpio_route #(.NL(NL), .NOUT(NOUT), .IW(IW)) u_route (
    .clk(clk), .rst_n(rst_sync_q), .req(req), .ridx(ridx), .ren(ren),
    .irq_o(irq_out)
  );

  assign pin_out = dout;
  assign pin_oe  = dir;
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int NLT = 12;
  localparam int NO  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata1;
  logic [NLT-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NO-1:0]  irq_out;
  logic [31:0] pout1, poe1;
  logic [3:0]  irq1;

  int checks = 0, fails = 0;
  logic [NLT-1:0] b_mask = '0, b_pol = '0, b_edge = '0, b_ren = '0;
  int b_ridx [NLT];
  logic [NLT-1:0] hist [0:63];

  always #10 clk = ~clk;

  gpio_irq_port #(.NLINES(NLT), .NOUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  gpio_irq_port #(.NLINES(40)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .pin_in(32'h0), .pin_out(pout1), .pin_oe(poe1), .irq_out(irq1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    tick(1);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_route(input int line, input int idx, input logic en);
    b_ridx[line] = idx; b_ren[line] = en;
    wr(8'h20 + 8'(4 * line), {23'd0, en, 6'd0, 2'(idx)});
  endtask

  function automatic logic [NO-1:0] exp_irq(input logic [NLT-1:0] c, input logic [NLT-1:0] o);
    logic [NO-1:0] r;
    logic a;
    r = '0;
    for (int i = 0; i < NLT; i++) begin
      if (b_edge[i]) a = b_pol[i] ? (c[i] && !o[i]) : (!c[i] && o[i]);
      else           a = (c[i] == b_pol[i]);
      if (a && b_mask[i] && b_ren[i] && b_ridx[i] < NO) r[b_ridx[i]] = 1'b1;
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NLT; i++) b_ridx[i] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R10 reset state
    chk("R10 pin_oe", 32'(pin_oe), 32'h0);
    chk("R10 pin_out", 32'(pin_out), 32'h0);
    chk("R10 irq", 32'(irq_out), 32'h0);
    rd(8'h0C, d); chk("R10 mask", d, 32'h0);
    rd(8'h20, d); chk("R10 route0", d, 32'h0);

    // R3 direction and output drive, R2 readback
    wr(8'h08, 32'h0000_0A5A);
    chk("R3 pin_oe", 32'(pin_oe), 32'h0A5A);
    wr(8'h04, 32'h0000_03C3);
    chk("R3 pin_out", 32'(pin_out), 32'h03C3);
    rd(8'h08, d); chk("R2 dir readback", d, 32'h0A5A);
    rd(8'h04, d); chk("R2 out readback", d, 32'h03C3);

    // R2 spare offset
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R2 spare offset", d, 32'h0);

    // R1 bits above line count; fallback count
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R1 upper bits", d, 32'h0000_0FFF);
    chk("R1 fallback 32 lines", poe1, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);

    // R4 synchroniser latency
    pin_in = 12'h5A3; tick(4);
    rd(8'h00, d); chk("R4 pin levels", d, 32'h5A3);
    pin_in = 12'h111;
    rd(8'h00, d); chk("R4 first read old", d, 32'h5A3);
    rd(8'h00, d); chk("R4 second read old", d, 32'h5A3);
    rd(8'h00, d); chk("R4 third read new", d, 32'h111);

    // R2 read-modify-write of mask
    wr(8'h0C, 32'h005);
    rd(8'h0C, d); wr(8'h0C, d | 32'h100);
    rd(8'h0C, d); chk("R2 mask rmw", d, 32'h105);
    wr(8'h0C, 32'h0); b_mask = '0;

    // R7 level-high line0 -> out1
    pin_in = '0;
    wr(8'h10, 32'h1); b_pol = 12'h1;
    wr(8'h14, 32'h0); b_edge = '0;
    set_route(0, 1, 1'b1);
    wr(8'h0C, 32'h1); b_mask = 12'h1;
    tick(3);
    chk("R7 inactive level", 32'(irq_out), 32'h0);
    pin_in = 12'h001;
    tick(3);
    chk("R7 level asserted", 32'(irq_out), 32'h2);
    tick(5);
    chk("R7 level held", 32'(irq_out), 32'h2);

    // R8 mask suppresses
    wr(8'h0C, 32'h0); b_mask = '0;
    tick(1);
    chk("R8 masked line", 32'(irq_out), 32'h0);

    // R5 level-low line1 -> out2, R9 routing cases
    set_route(1, 2, 1'b1);
    wr(8'h0C, 32'h2); b_mask = 12'h2;
    tick(1);
    chk("R5 level-low", 32'(irq_out), 32'h4);
    set_route(1, 3, 1'b1);
    tick(1);
    chk("R9 index out of range", 32'(irq_out), 32'h0);
    set_route(1, 2, 1'b0);
    tick(1);
    chk("R9 route disabled", 32'(irq_out), 32'h0);
    set_route(1, 2, 1'b1);
    set_route(0, 2, 1'b1);
    wr(8'h0C, 32'h3); b_mask = 12'h3;
    tick(1);
    chk("R9 shared output", 32'(irq_out), 32'h4);
    pin_in = 12'h000;
    tick(3);
    chk("R9 shared OR one line", 32'(irq_out), 32'h4);
    wr(8'h0C, 32'h0); b_mask = '0;

    // R6 rising edge line2 -> out0, single pulse
    wr(8'h10, 32'h4); b_pol = 12'h4;
    wr(8'h14, 32'h4); b_edge = 12'h4;
    set_route(2, 0, 1'b1);
    wr(8'h0C, 32'h4); b_mask = 12'h4;
    tick(3);
    pin_in = 12'h004;
    tick(1); chk("R6 rise +1", 32'(irq_out), 32'h0);
    tick(1); chk("R6 rise +2", 32'(irq_out), 32'h0);
    tick(1); chk("R6 rise pulse", 32'(irq_out), 32'h1);
    tick(1); chk("R6 rise pulse ends", 32'(irq_out), 32'h0);
    // R5 falling edge mode
    wr(8'h10, 32'h0); b_pol = '0;
    tick(2);
    pin_in = 12'h000;
    tick(3); chk("R5 falling pulse", 32'(irq_out), 32'h1);
    tick(1); chk("R5 falling pulse ends", 32'(irq_out), 32'h0);

    // R5 R6 R7 R9 random configurations and pin streams
    for (int t = 0; t < 8; t++) begin
      logic [NLT-1:0] hold;
      hold   = NLT'($urandom);
      b_mask = NLT'($urandom);
      b_pol  = NLT'($urandom);
      b_edge = NLT'($urandom);
      wr(8'h0C, 32'(b_mask));
      wr(8'h10, 32'(b_pol));
      wr(8'h14, 32'(b_edge));
      for (int i = 0; i < NLT; i++) set_route(i, int'($urandom % 4), ($urandom % 4) != 0);
      pin_in = hold;
      tick(4);
      hist[0] = hold; hist[1] = hold; hist[2] = hold;
      for (int k = 3; k < 60; k++) begin
        hist[k] = (k % 5 == 0) ? hist[k-1] : NLT'($urandom);
        pin_in = hist[k];
        tick(1);
        chk("R5 R6 R7 R9 random irq", 32'(irq_out), 32'(exp_irq(hist[k-2], hist[k-3])));
      end
    end

    finish_run();
  end
endmodule